// File: doc/BRIEF.md
# Transmit Descriptor Ring Poll Controller

This block walks a ring of transmit descriptors that live in host memory and decides, one entry at a time, whether to wait, hand the entry back to software, or start moving its buffer toward the transmitter. Each descriptor word carries an ownership flag, a start-of-packet flag, an end-of-packet flag, three status flags (error, buffer error, underflow) and a buffer length. The controller never moves frame data itself. It issues descriptor read and write requests on a valid/ready request port, accepts read data on a valid/ready response port, and hands a buffer to an external data mover through a valid/ready start handshake. The data mover then reports back with single-cycle pulses: a data beat taken from the buffer, the buffer drained, or a transmit error.

Polling starts in a countdown state. It is triggered by a programmable interval timer, by a software demand strobe, or by a received-frame pulse, and it runs only while the transmitter is enabled and polling is not disabled. When the receive side does not yet own its own descriptor, a receive-descriptor check handshake comes before the transmit read. Chained buffers are followed by a lookahead read of the next entry. If that lookahead finds the next entry not owned, the current entry is marked with an underflow status. The transmitter then either halts or recovers, as selected by an input. A frame that fails part-way through its chain is abandoned by releasing the rest of its entries.

Every valid/ready port follows one back-pressure rule. Once a valid is raised, it stays high with its payload unchanged until the cycle in which ready is seen, and the transfer takes place on that clock edge. The controller holds the response port's ready high only while it is waiting for read data.

Top module: `txring_poller`

## Requirements
- R1: After reset the block sits in the countdown state and issues no request. While `tx_en_i`=1 and `poll_dis_i`=0, a poll (a descriptor read of the current index) starts when the interval expires or when `rx_frame_i` pulses in the countdown state. While polling is disabled, no poll starts, and `rx_frame_i` and `demand_i` are ignored.
- R2: The interval is `poll_ival_i` clock cycles. A value of 0 selects the default of 65,536 cycles. Between two polls of a non-owned entry, the spacing is the interval plus at most a few cycles of fixed overhead.
- R3: A `demand_i` pulse in the countdown state starts a poll at once, without waiting for the timer. A pulse that arrives while a poll is in progress is remembered, and a new poll starts as soon as the block returns to the countdown state.
- R4: When `rx_owned_i`=0 at the start of a poll, one handshake on `rxchk_valid_o`/`rxchk_ready_i` completes before the descriptor read.
- R5: Descriptor word layout: bit 17 ownership, bit 16 start-of-packet, bit 15 end-of-packet, bit 14 error, bit 13 buffer error, bit 12 underflow, bits 11:0 buffer length. If a read entry has ownership 0, the block returns to the countdown state and the index does not advance.
- R6: If a read entry has ownership 1 and either start-of-packet 0 or length 0, it is written back at the same index with only bit 17 cleared. The next index is then read at once, with no countdown and no receive check.
- R7: If a read entry has ownership, start-of-packet and a non-zero length, a start request carries its index and length. A lookahead read of the next index is issued only when end-of-packet is 0, and only after the first data beat or the buffer-drained pulse.
- R8: When the buffer of an end-of-packet entry drains, the entry is written back with bit 17 cleared and all status bits 0. A new poll of the next index then follows at once, including the receive check when `rx_owned_i`=0.
- R9: When the buffer drains and the lookahead entry is owned, the current entry is written back with bit 17 cleared. A start request for the next index with that entry's length follows.
- R10: When the buffer drains and the lookahead entry is not owned, the current entry is written back with bit 17 cleared and bits 13 and 12 set. With `recover_en_i`=0, `tx_halt_o` then rises, and no request is made until `tx_en_i` goes low. With `recover_en_i`=1, the next index is polled at once.
- R11: An `mv_err_i` pulse during a transfer writes the current entry back with bit 17 cleared and bit 14 set, and then polls the next index at once. Owned entries with start-of-packet 0 that follow are released by the R6 rule.
- R12: The ring index steps by one after each write-back and wraps from `RING_DEPTH`-1 to 0.
- R13: A raised `dreq_valid_o` or `xfer_valid_o` stays high with a stable payload until its ready is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| tx_en_i | input | 1 | Transmitter enabled |
| poll_dis_i | input | 1 | Disable automatic polling |
| recover_en_i | input | 1 | Graceful underflow recovery |
| poll_ival_i | input | IVAL_W | Poll interval in cycles, 0 selects the default |
| demand_i | input | 1 | Software poll demand pulse |
| rx_frame_i | input | 1 | A frame was just received |
| rx_owned_i | input | 1 | Receive descriptor already owned |
| rxchk_valid_o | output | 1 | Receive descriptor check request |
| rxchk_ready_i | input | 1 | Receive check accepted |
| dreq_valid_o | output | 1 | Descriptor request valid |
| dreq_ready_i | input | 1 | Descriptor request accepted |
| dreq_wr_o | output | 1 | 1 = write, 0 = read |
| dreq_idx_o | output | RING_W | Ring index of the request |
| dreq_wdata_o | output | DESC_W | Descriptor word to write |
| drsp_valid_i | input | 1 | Read data valid |
| drsp_ready_o | output | 1 | Ready for read data |
| drsp_data_i | input | DESC_W | Read descriptor word |
| xfer_valid_o | output | 1 | Start-transfer request valid |
| xfer_ready_i | input | 1 | Data mover accepted the start |
| xfer_idx_o | output | RING_W | Index of the buffer to move |
| xfer_len_o | output | LEN_W | Buffer length |
| mv_beat_i | input | 1 | Data beat taken from the buffer |
| mv_end_i | input | 1 | Buffer drained |
| mv_err_i | input | 1 | Transmit error |
| tx_halt_o | output | 1 | Transmitter halted after underflow |

## Verification
A wrong ring index or a lost event shows at the descriptor port within one poll. The next read or write carries the wrong index, or a skipped release appears as a missing write, so the order of requests gives the error away within a few cycles of the triggering pulse. A wrong timer or demand latch shows only in the spacing between polls, which can take up to one full interval to reveal itself. For that reason the request stream is compared in order against an expected queue, and poll spacing is measured in cycles. Status bit mistakes appear in the write data of the very write-back that follows a drain or an error.

// File: rtl/txring_pkg.sv
package txring_pkg;
  localparam int LEN_W = 12;

  typedef struct packed {
    logic             own;
    logic             stp;
    logic             enp;
    logic             err;
    logic             buff;
    logic             uflo;
    logic [LEN_W-1:0] len;
  } txdesc_t;

  localparam int DESC_W = $bits(txdesc_t);

  typedef enum logic [3:0] {
    S_WAIT, S_RXCHK, S_RD, S_RDW, S_EVAL, S_REL,
    S_START, S_XFER, S_LA, S_LAW, S_WB, S_HALT
  } txr_state_e;

  typedef enum logic [1:0] {WB_POLL, WB_CHAIN, WB_HALT} wb_next_e;
endpackage

// File: rtl/txr_poll_timer.sv
module txr_poll_timer #(
  parameter int IVAL_W   = 17,
  parameter int DEF_IVAL = 65536
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              restart_i,
  input  logic              run_i,
  input  logic [IVAL_W-1:0] ival_i,
  output logic              expire_o
);
  localparam logic [IVAL_W-1:0] DEF_V = IVAL_W'(DEF_IVAL);

  logic [IVAL_W-1:0] cnt_q;
  logic [IVAL_W-1:0] ival_eff;

  assign ival_eff = (ival_i == '0) ? DEF_V : ival_i;
  assign expire_o = run_i && (cnt_q >= ival_eff - IVAL_W'(1));

  always_ff @(posedge clk_i) begin
    if (!rst_ni || restart_i) cnt_q <= '0;
    else if (run_i)           cnt_q <= expire_o ? '0 : cnt_q + IVAL_W'(1);
  end

  // R2: the count never moves while the countdown is stopped
  assert_hold_when_stopped_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !restart_i) |=> $stable(cnt_q));
endmodule

// File: rtl/txr_ring_ptr.sv
module txr_ring_ptr #(
  parameter int RING_DEPTH = 16,
  localparam int RING_W = $clog2(RING_DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              adv_i,
  output logic [RING_W-1:0] idx_o,
  output logic [RING_W-1:0] idx_next_o
);
  logic [RING_W-1:0] idx_q;

  assign idx_o      = idx_q;
  assign idx_next_o = idx_q + RING_W'(1);

  always_ff @(posedge clk_i) begin
    if (!rst_ni)    idx_q <= '0;
    else if (adv_i) idx_q <= idx_next_o;
  end

  assert_wrap_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && idx_q == RING_W'(RING_DEPTH - 1)) |=> (idx_q == '0));
  assert_steady_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(idx_q));
endmodule

// File: rtl/txring_poller.sv
module txring_poller
  import txring_pkg::*;
#(
  parameter int RING_DEPTH = 16,
  parameter int IVAL_W     = 17,
  parameter int DEF_IVAL   = 65536,
  localparam int RING_W    = $clog2(RING_DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tx_en_i,
  input  logic              poll_dis_i,
  input  logic              recover_en_i,
  input  logic [IVAL_W-1:0] poll_ival_i,
  input  logic              demand_i,
  input  logic              rx_frame_i,
  input  logic              rx_owned_i,
  output logic              rxchk_valid_o,
  input  logic              rxchk_ready_i,
  output logic              dreq_valid_o,
  input  logic              dreq_ready_i,
  output logic              dreq_wr_o,
  output logic [RING_W-1:0] dreq_idx_o,
  output logic [DESC_W-1:0] dreq_wdata_o,
  input  logic              drsp_valid_i,
  output logic              drsp_ready_o,
  input  logic [DESC_W-1:0] drsp_data_i,
  output logic              xfer_valid_o,
  input  logic              xfer_ready_i,
  output logic [RING_W-1:0] xfer_idx_o,
  output logic [LEN_W-1:0]  xfer_len_o,
  input  logic              mv_beat_i,
  input  logic              mv_end_i,
  input  logic              mv_err_i,
  output logic              tx_halt_o
);
  txr_state_e state_q;
  txdesc_t    cur_q, la_q, wb_q, rel_word;
  wb_next_e   wb_next_q;
  logic       la_done_q, ev_beat_q, ev_end_q, ev_err_q, dem_pend_q;
  logic       poll_en, expire, adv, in_xfer;
  logic [RING_W-1:0] idx, idx_nxt;
  txr_state_e poll_entry;

  assign poll_en    = tx_en_i && !poll_dis_i;
  assign poll_entry = rx_owned_i ? S_RD : S_RXCHK;
  assign in_xfer    = (state_q == S_XFER) || (state_q == S_LA) || (state_q == S_LAW);

  txr_poll_timer #(.IVAL_W(IVAL_W), .DEF_IVAL(DEF_IVAL)) timer_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (state_q != S_WAIT),
    .run_i     ((state_q == S_WAIT) && poll_en),
    .ival_i    (poll_ival_i),
    .expire_o  (expire)
  );

  assign adv = ((state_q == S_REL) || (state_q == S_WB)) && dreq_ready_i;

  txr_ring_ptr #(.RING_DEPTH(RING_DEPTH)) ptr_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .adv_i      (adv),
    .idx_o      (idx),
    .idx_next_o (idx_nxt)
  );

  always_comb begin
    rel_word     = cur_q;
    rel_word.own = 1'b0;
  end

  assign rxchk_valid_o = (state_q == S_RXCHK);
  assign dreq_valid_o  = (state_q == S_RD) || (state_q == S_LA) ||
                         (state_q == S_REL) || (state_q == S_WB);
  assign dreq_wr_o     = (state_q == S_REL) || (state_q == S_WB);
  assign dreq_idx_o    = (state_q == S_LA) ? idx_nxt : idx;
  assign dreq_wdata_o  = (state_q == S_REL) ? rel_word :
                         (state_q == S_WB)  ? wb_q : '0;
  assign drsp_ready_o  = (state_q == S_RDW) || (state_q == S_LAW);
  assign xfer_valid_o  = (state_q == S_START);
  assign xfer_idx_o    = idx;
  assign xfer_len_o    = cur_q.len;
  assign tx_halt_o     = (state_q == S_HALT);

  // Event latches for the data mover pulses
  always_ff @(posedge clk_i) begin
    if (!rst_ni || (state_q == S_START)) begin
      ev_beat_q <= 1'b0;
      ev_end_q  <= 1'b0;
      ev_err_q  <= 1'b0;
    end else if (in_xfer) begin
      ev_beat_q <= ev_beat_q | mv_beat_i;
      ev_end_q  <= ev_end_q  | mv_end_i;
      ev_err_q  <= ev_err_q  | mv_err_i;
    end
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      state_q    <= S_WAIT;
      cur_q      <= '0;
      la_q       <= '0;
      wb_q       <= '0;
      wb_next_q  <= WB_POLL;
      la_done_q  <= 1'b0;
      dem_pend_q <= 1'b0;
    end else begin
      if (demand_i && poll_en && state_q != S_WAIT) dem_pend_q <= 1'b1;
      unique case (state_q)
        S_WAIT: if (poll_en && (expire || rx_frame_i || demand_i || dem_pend_q)) begin
          state_q    <= poll_entry;
          dem_pend_q <= 1'b0;
        end
        S_RXCHK: if (rxchk_ready_i) state_q <= S_RD;
        S_RD:    if (dreq_ready_i)  state_q <= S_RDW;
        S_RDW: if (drsp_valid_i) begin
          cur_q   <= txdesc_t'(drsp_data_i);
          state_q <= S_EVAL;
        end
        S_EVAL: begin
          if (!cur_q.own)                          state_q <= S_WAIT;
          else if (!cur_q.stp || cur_q.len == '0) state_q <= S_REL;
          else                                     state_q <= S_START;
        end
        S_REL: if (dreq_ready_i) state_q <= S_RD;
        S_START: if (xfer_ready_i) begin
          la_done_q <= 1'b0;
          state_q   <= S_XFER;
        end
        S_XFER: begin
          wb_q      <= rel_word;
          wb_q.err  <= 1'b0;
          wb_q.buff <= 1'b0;
          wb_q.uflo <= 1'b0;
          if (ev_err_q) begin
            wb_q.err  <= 1'b1;
            wb_next_q <= WB_POLL;
            state_q   <= S_WB;
          end else if (ev_end_q && cur_q.enp) begin
            wb_next_q <= WB_POLL;
            state_q   <= S_WB;
          end else if (ev_end_q && la_done_q) begin
            if (la_q.own) begin
              wb_next_q <= WB_CHAIN;
            end else begin
              wb_q.buff <= 1'b1;
              wb_q.uflo <= 1'b1;
              wb_next_q <= recover_en_i ? WB_POLL : WB_HALT;
            end
            state_q <= S_WB;
          end else if (!cur_q.enp && !la_done_q && (ev_beat_q || ev_end_q)) begin
            state_q <= S_LA;
          end
        end
        S_LA:  if (dreq_ready_i) state_q <= S_LAW;
        S_LAW: if (drsp_valid_i) begin
          la_q      <= txdesc_t'(drsp_data_i);
          la_done_q <= 1'b1;
          state_q   <= S_XFER;
        end
        S_WB: if (dreq_ready_i) begin
          unique case (wb_next_q)
            WB_CHAIN: begin
              cur_q   <= la_q;
              state_q <= S_START;
            end
            WB_HALT: state_q <= S_HALT;
            default: state_q <= poll_entry;
          endcase
        end
        S_HALT: if (!tx_en_i) state_q <= S_WAIT;
        default: state_q <= S_WAIT;
      endcase
    end
  end

  assert_req_hold_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dreq_valid_o && !dreq_ready_i) |=> (dreq_valid_o && $stable(dreq_wr_o) &&
      $stable(dreq_idx_o) && $stable(dreq_wdata_o)));
  assert_xfer_hold_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_valid_o && !xfer_ready_i) |=> (xfer_valid_o && $stable(xfer_idx_o) &&
      $stable(xfer_len_o)));
  assert_wr_releases_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dreq_valid_o && dreq_wr_o) |-> !dreq_wdata_o[DESC_W-1]);
  assert_quiet_when_off_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_WAIT && !poll_en) |=> (!dreq_valid_o && !rxchk_valid_o));
  assert_halt_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_halt_o |-> (!dreq_valid_o && !xfer_valid_o && !rxchk_valid_o));
  assert_la_after_beat_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_LA) |-> ((ev_beat_q || ev_end_q) && !cur_q.enp));
endmodule

// File: tb/txring_poller_tb_top.sv
module txring_poller_tb_top;
  import txring_pkg::*;

  localparam int RW = 4;
  localparam logic [1:0] K_RX = 2'd0, K_RD = 2'd1, K_WR = 2'd2, K_XF = 2'd3;
  localparam logic [17:0] ERR = 18'h04000, BUFF = 18'h02000, UFLO = 18'h01000;

  typedef struct packed {
    logic [1:0]  kind;
    logic [3:0]  idx;
    logic [17:0] data;
  } item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_en = 1'b0, poll_dis = 1'b0, recover_en = 1'b0;
  logic [16:0] ival = 17'd20;
  logic demand = 1'b0, rx_frame = 1'b0, rx_owned = 1'b1;
  logic rxchk_valid, dreq_valid, dreq_wr, drsp_ready, xfer_valid, tx_halt;
  logic dreq_ready = 1'b1;
  logic [RW-1:0] dreq_idx, xfer_idx;
  logic [17:0] dreq_wdata, drsp_data = '0;
  logic drsp_valid = 1'b0;
  logic [11:0] xfer_len;
  logic mv_beat = 1'b0, mv_end = 1'b0, mv_err = 1'b0;

  always #2.5 clk = ~clk;

  txring_poller dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tx_en_i(tx_en), .poll_dis_i(poll_dis),
    .recover_en_i(recover_en), .poll_ival_i(ival), .demand_i(demand),
    .rx_frame_i(rx_frame), .rx_owned_i(rx_owned),
    .rxchk_valid_o(rxchk_valid), .rxchk_ready_i(1'b1),
    .dreq_valid_o(dreq_valid), .dreq_ready_i(dreq_ready), .dreq_wr_o(dreq_wr),
    .dreq_idx_o(dreq_idx), .dreq_wdata_o(dreq_wdata),
    .drsp_valid_i(drsp_valid), .drsp_ready_o(drsp_ready), .drsp_data_i(drsp_data),
    .xfer_valid_o(xfer_valid), .xfer_ready_i(1'b1), .xfer_idx_o(xfer_idx),
    .xfer_len_o(xfer_len), .mv_beat_i(mv_beat), .mv_end_i(mv_end),
    .mv_err_i(mv_err), .tx_halt_o(tx_halt)
  );

  int checks = 0, fails = 0, cyc = 0;
  int rd_cyc = 0, prev_rd_cyc = 0;
  string cur_req = "R1";
  item_t exp_q[$];
  logic [17:0] mem [16];
  logic bp_en = 1'b0;
  logic done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [17:0] mk(input bit own, input bit stp, input bit enp,
                                     input int len);
    return {own, stp, enp, 3'b000, 12'(len)};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push(input logic [1:0] k, input int idx, input logic [17:0] d);
    exp_q.push_back({k, 4'(idx), d});
  endtask

  task automatic got(input item_t it);
    item_t e;
    checks++;
    if (exp_q.size() == 0) begin
      fails++;
      $display("FAIL %s unexpected actual=%h expected=none", cur_req, it);
    end else begin
      e = exp_q.pop_front();
      if (e != it) begin
        fails++;
        $display("FAIL %s actual=%h expected=%h", cur_req, it, e);
      end
    end
  endtask

  // Scoreboard monitor and R13 stall check, sampled at the falling edge
  logic stall_q = 1'b0;
  logic [22:0] stall_pl = '0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (stall_q)
        chk(dreq_valid && {dreq_wr, dreq_idx, dreq_wdata} == stall_pl, "R13",
            int'({dreq_valid, dreq_idx}), int'({1'b1, stall_pl[21:18]}));
      stall_q  <= dreq_valid && !dreq_ready;
      stall_pl <= {dreq_wr, dreq_idx, dreq_wdata};
      if (rxchk_valid) got({K_RX, 4'd0, 18'd0});
      if (dreq_valid && dreq_ready) begin
        got({dreq_wr ? K_WR : K_RD, dreq_idx, dreq_wr ? dreq_wdata : 18'd0});
        if (dreq_wr) mem[dreq_idx] = dreq_wdata;
        else begin
          prev_rd_cyc = rd_cyc;
          rd_cyc = cyc;
        end
      end
      if (xfer_valid) got({K_XF, xfer_idx, {6'd0, xfer_len}});
    end
  end

  // Memory responder: one cycle of read latency
  initial begin
    logic pend;
    logic [3:0] pidx;
    logic taken;
    pend = 0; pidx = 0; taken = 0;
    forever begin
      @(negedge clk);
      taken = drsp_valid && drsp_ready;
      if (dreq_valid && dreq_ready && !dreq_wr) begin
        pend = 1; pidx = dreq_idx;
      end
      @(posedge clk);
      #1;
      if (taken) drsp_valid = 1'b0;
      if (pend) begin
        drsp_valid = 1'b1;
        drsp_data  = mem[pidx];
        pend = 0;
      end
      dreq_ready = bp_en ? cyc[1] : 1'b1;
    end
  end

  task automatic pulse(input int which);
    @(posedge clk); #1;
    case (which)
      0: demand = 1'b1;
      1: rx_frame = 1'b1;
      2: mv_beat = 1'b1;
      3: mv_end = 1'b1;
      default: mv_err = 1'b1;
    endcase
    @(posedge clk); #1;
    demand = 1'b0; rx_frame = 1'b0; mv_beat = 1'b0; mv_end = 1'b0; mv_err = 1'b0;
  endtask

  task automatic drain(input int limit);
    int n = 0;
    while (exp_q.size() != 0 && n < limit) begin
      @(negedge clk);
      n++;
    end
    chk(exp_q.size() == 0, cur_req, exp_q.size(), 0);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task summary;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    wait (cyc >= 190000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=<190000", cyc);
      summary();
    end
  end

  initial begin
    int t;
    for (int i = 0; i < 16; i++) mem[i] = '0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    idle(2);
    // R1: reset state, quiet
    chk(!dreq_valid && !xfer_valid && !rxchk_valid && !tx_halt, "R1",
        int'({dreq_valid, xfer_valid, rxchk_valid, tx_halt}), 0);

    // R1/R2/R5: timer polls of a non-owned entry at index 0
    cur_req = "R2";
    push(K_RD, 0, 0); push(K_RD, 0, 0);
    @(posedge clk); #1 tx_en = 1'b1;
    drain(200);
    chk((rd_cyc - prev_rd_cyc) >= 20 && (rd_cyc - prev_rd_cyc) <= 26, "R2",
        rd_cyc - prev_rd_cyc, 22);
    @(posedge clk); #1 ival = 17'd5000;

    // R3: demand from countdown, then demand while busy
    cur_req = "R3";
    idle(5);
    t = cyc;
    push(K_RD, 0, 0);
    pulse(0);
    drain(50);
    chk(rd_cyc - t <= 4, "R3", rd_cyc - t, 2);
    push(K_RD, 0, 0); push(K_RD, 0, 0);
    pulse(0);
    while (exp_q.size() > 1) @(negedge clk);
    t = rd_cyc;
    pulse(0);
    drain(50);
    chk(rd_cyc - t <= 8, "R3", rd_cyc - t, 6);

    // R1: disabled polling ignores rx_frame and demand
    cur_req = "R1";
    @(posedge clk); #1 poll_dis = 1'b1;
    pulse(1); pulse(0);
    idle(100);
    chk(exp_q.size() == 0 && !dreq_valid, "R1", int'(dreq_valid), 0);
    @(posedge clk); #1 poll_dis = 1'b0;
    push(K_RD, 0, 0);
    pulse(1);
    drain(20);

    // R4: receive check before the read
    cur_req = "R4";
    @(posedge clk); #1 rx_owned = 1'b0;
    push(K_RX, 0, 0); push(K_RD, 0, 0);
    pulse(0);
    drain(50);
    @(posedge clk); #1 rx_owned = 1'b1;

    // R6/R5: release non-start entry and zero-length entry
    cur_req = "R6";
    mem[0] = mk(1, 0, 0, 5); mem[1] = mk(1, 1, 0, 0);
    push(K_RD, 0, 0); push(K_WR, 0, mk(0, 0, 0, 5));
    push(K_RD, 1, 0); push(K_WR, 1, mk(0, 1, 0, 0));
    push(K_RD, 2, 0);
    pulse(0);
    drain(100);

    // R7/R8: single buffer frame, no lookahead
    cur_req = "R7";
    mem[2] = mk(1, 1, 1, 100);
    push(K_RD, 2, 0); push(K_XF, 2, 18'd100);
    pulse(0);
    drain(50);
    pulse(2);
    idle(10);
    chk(exp_q.size() == 0 && !dreq_valid, "R7", int'(dreq_valid), 0);
    cur_req = "R8";
    push(K_WR, 2, mk(0, 1, 1, 100)); push(K_RD, 3, 0);
    pulse(3);
    drain(50);

    // R9: two-buffer chain, lookahead only after a beat
    cur_req = "R9";
    mem[3] = mk(1, 1, 0, 10); mem[4] = mk(1, 0, 1, 20);
    push(K_RD, 3, 0); push(K_XF, 3, 18'd10);
    pulse(0);
    drain(50);
    idle(10);
    chk(!dreq_valid, "R7", int'(dreq_valid), 0);
    push(K_RD, 4, 0);
    pulse(2);
    drain(50);
    push(K_WR, 3, mk(0, 1, 0, 10)); push(K_XF, 4, 18'd20);
    pulse(3);
    drain(50);
    push(K_WR, 4, mk(0, 0, 1, 20)); push(K_RD, 5, 0);
    pulse(2); pulse(3);
    drain(50);

    // R10: underflow, recovery off -> halt
    cur_req = "R10";
    mem[5] = mk(1, 1, 0, 8);
    push(K_RD, 5, 0); push(K_XF, 5, 18'd8); push(K_RD, 6, 0);
    pulse(0);
    while (exp_q.size() > 1) @(negedge clk);
    pulse(2);
    drain(50);
    push(K_WR, 5, mk(0, 1, 0, 8) | BUFF | UFLO);
    pulse(3);
    drain(50);
    idle(20);
    chk(tx_halt == 1'b1, "R10", int'(tx_halt), 1);
    pulse(0);
    idle(20);
    chk(exp_q.size() == 0 && !dreq_valid, "R10", int'(dreq_valid), 0);
    @(posedge clk); #1 tx_en = 1'b0;
    idle(3);
    chk(tx_halt == 1'b0, "R10", int'(tx_halt), 0);
    @(posedge clk); #1 tx_en = 1'b1;

    // R10: underflow with recovery on
    @(posedge clk); #1 recover_en = 1'b1;
    mem[6] = mk(1, 1, 0, 4);
    push(K_RD, 6, 0); push(K_XF, 6, 18'd4); push(K_RD, 7, 0);
    pulse(0);
    while (exp_q.size() > 1) @(negedge clk);
    pulse(2);
    drain(50);
    push(K_WR, 6, mk(0, 1, 0, 4) | BUFF | UFLO); push(K_RD, 7, 0);
    pulse(3);
    drain(50);
    chk(tx_halt == 1'b0, "R10", int'(tx_halt), 0);

    // R11: error mid-chain skips the rest of the frame
    cur_req = "R11";
    mem[7] = mk(1, 1, 0, 30); mem[8] = mk(1, 0, 0, 7); mem[9] = mk(1, 0, 1, 9);
    push(K_RD, 7, 0); push(K_XF, 7, 18'd30);
    pulse(0);
    drain(50);
    push(K_WR, 7, mk(0, 1, 0, 30) | ERR);
    push(K_RD, 8, 0); push(K_WR, 8, mk(0, 0, 0, 7));
    push(K_RD, 9, 0); push(K_WR, 9, mk(0, 0, 1, 9));
    push(K_RD, 10, 0);
    pulse(4);
    drain(100);

    // R12/R13: wrap of the ring under request back-pressure
    cur_req = "R12";
    for (int i = 10; i < 16; i++) mem[i] = mk(1, 0, 0, i);
    for (int i = 10; i < 16; i++) begin
      push(K_RD, i, 0); push(K_WR, i, mk(0, 0, 0, i));
    end
    push(K_RD, 0, 0);
    @(posedge clk); #1 bp_en = 1'b1;
    pulse(0);
    drain(300);
    @(posedge clk); #1 bp_en = 1'b0;
    idle(4);

    // R2: default interval when the interval input is 0
    cur_req = "R2";
    @(posedge clk); #1 ival = '0;
    push(K_RD, 0, 0); push(K_RD, 0, 0);
    pulse(0);
    drain(70000);
    chk((rd_cyc - prev_rd_cyc) >= 65536 && (rd_cyc - prev_rd_cyc) <= 65542, "R2",
        rd_cyc - prev_rd_cyc, 65538);

    done = 1'b1;
    summary();
  end
endmodule